// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block sequences a single programmed-I/O access on an IDE-style bus. Each access passes through four phases: IDLE, SETUP, ACTIVE and HOLD. The length of each phase is counted in bus clocks. Every access request carries a direction (read or write) and a port class (data port or command/control port). The class picks one of two 8-bit timing bytes, and the setup, active and hold counts are decoded from that byte. Both drives on the channel use the same pair of timing bytes.

During ACTIVE the block drives the read or write strobe, depending on the direction. If IORDY waiting is enabled, a low IORDY on the final ACTIVE clock keeps ACTIVE running. Read data is captured at the end of ACTIVE, and write data is driven for the whole access. A single-cycle done pulse marks the end of HOLD. Requests are taken only while the block is idle. The timing and the per-access configuration are latched at acceptance, so later input changes cannot disturb an access that is already running.

Top module: `ide_pio_timer`

## Requirements
- R1: The setup phase (chip select active, no strobe) lasts 1, 2, 3 or 4 clocks for timing-byte bits [7:6] = 0, 1, 2, 3.
- R2: With no IORDY stretch, the strobe lasts 2, 3, 4, 5, 6, 8, 12 or 16 clocks for timing-byte bits [2:0] = 0..7.
- R3: The hold phase (chip select active after the strobe, done cycle included) lasts 1, 2, 3, 4, 5, 6, 8 or 12 clocks for timing-byte bits [5:3] = 0..7.
- R4: `req_cmd`=0 uses `data_timing` and asserts `cs_data`. `req_cmd`=1 uses `cmd_timing` and asserts `cs_cmd`. The selected chip select stays high from the first setup clock to the last hold clock, and the other one stays low.
- R5: A strobe appears only between setup and hold. It is `rd_strobe` for `req_write`=0 and `wr_strobe` for `req_write`=1, and the two are never high together.
- R6: With IORDY waiting enabled, if IORDY is low on the last ACTIVE clock, the strobe continues until the first clock on which IORDY is high. The strobe length is therefore max(nominal, L+1) when IORDY is low for the first L strobe clocks. With waiting disabled, IORDY has no effect.
- R7: A read loads `rd_data` with `rd_bus` as sampled on the final strobe clock. For command-class accesses, and for data-class accesses with `narrow_en`=1, bits [15:8] are loaded as 0. A write leaves `rd_data` unchanged.
- R8: During a write, `bus_oe` is high on every clock that a chip select is high, and `bus_wdata` equals `wdata_in`. Bits [15:8] are forced to 0 under the same narrow rules as R7. During a read, `bus_oe` is low.
- R9: `done` is high for exactly one clock, the last hold clock. `req_ready` is high only when idle. A request raised while an access is running is dropped and does not start an access afterwards.
- R10: The timing bytes, `iordy_en`, `narrow_en`, direction, class and `wdata_in` are latched when a request is accepted. Changing them during an access has no effect on that access.
- R11: After reset the block is idle: `req_ready`=1, both chip selects low, both strobes low, `bus_oe`=0, `done`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cmd | input | 1 | 1 = command/control port class, 0 = data port class |
| req_ready | output | 1 | Block is idle and can accept a request |
| data_timing | input | 8 | Timing byte for data-port accesses |
| cmd_timing | input | 8 | Timing byte for command/control accesses |
| iordy_en | input | 1 | Enables IORDY wait stretching |
| narrow_en | input | 1 | Data port is 8 bits wide |
| wdata_in | input | 16 | Write data for the request |
| cs_data | output | 1 | Data-port chip select, high from setup through hold |
| cs_cmd | output | 1 | Command-port chip select, high from setup through hold |
| rd_strobe | output | 1 | Read strobe, high during ACTIVE |
| wr_strobe | output | 1 | Write strobe, high during ACTIVE |
| iordy | input | 1 | Device ready, low to extend ACTIVE |
| bus_wdata | output | 16 | Write data driven to the bus |
| bus_oe | output | 1 | Bus output enable during a write |
| rd_bus | input | 16 | Read data from the bus |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
The hardest cases to reach are an IORDY stall that ends exactly on, before or after the nominal last ACTIVE clock, and a request that arrives while the block is busy. The bench follows the strobe clock by clock, lowers IORDY for a chosen number of strobe clocks, and computes the expected strobe length as max(nominal, L+1). In the same accesses it scrambles the timing bytes and configuration inputs and raises a stray request during ACTIVE. It also changes `rd_bus` on every clock, so a capture one clock early or late reads the wrong value.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } pio_phase_e;

  // phase lengths stored as (clocks - 1)
  typedef struct packed {
    logic [CNT_W-1:0] setup_m1;
    logic [CNT_W-1:0] active_m1;
    logic [CNT_W-1:0] hold_m1;
  } pio_tim_t;

  function automatic logic [CNT_W-1:0] setup_m1_of(input logic [1:0] code);
    return CNT_W'(code);
  endfunction

  function automatic logic [CNT_W-1:0] hold_m1_of(input logic [2:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      3'd6:    r = CNT_W'(7);
      3'd7:    r = CNT_W'(11);
      default: r = CNT_W'(code);
    endcase
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] active_m1_of(input logic [2:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      3'd5:    r = CNT_W'(7);
      3'd6:    r = CNT_W'(11);
      3'd7:    r = CNT_W'(15);
      default: r = CNT_W'(code) + CNT_W'(1);
    endcase
    return r;
  endfunction

  function automatic pio_tim_t decode_timing(input logic [7:0] tb);
    pio_tim_t t;
    t.setup_m1  = setup_m1_of(tb[7:6]);
    t.hold_m1   = hold_m1_of(tb[5:3]);
    t.active_m1 = active_m1_of(tb[2:0]);
    return t;
  endfunction

endpackage

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
  import ide_pio_pkg::*;
(
  input  logic       sel_cmd,
  input  logic [7:0] data_tb,
  input  logic [7:0] cmd_tb,
  output pio_tim_t   tim
);

  logic [7:0] chosen;

  always_comb begin
    chosen = sel_cmd ? cmd_tb : data_tb;
    tim    = decode_timing(chosen);
  end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import ide_pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  pio_tim_t   tim_in,
  input  logic       ioen_in,
  input  logic       iordy,
  output pio_phase_e phase,
  output logic       capture,
  output logic       done
);

  pio_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_len_q, hold_len_q;
  logic             ioen_q;
  logic             stall;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign stall    = ioen_q && !iordy;

  // next state
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = tim_in.setup_m1;
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_ACTIVE;
          cnt_d   = act_len_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!stall) begin
          phase_d = PH_HOLD;
          cnt_d   = hold_len_q;
        end
      end
      PH_HOLD: begin
        if (cnt_zero) phase_d = PH_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // timing latch, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_len_q  <= '0;
      hold_len_q <= '0;
      ioen_q     <= 1'b0;
    end else if (start) begin
      act_len_q  <= tim_in.active_m1;
      hold_len_q <= tim_in.hold_m1;
      ioen_q     <= ioen_in;
    end
  end

  assign phase   = phase_q;
  assign capture = (phase_q == PH_ACTIVE) && cnt_zero && !stall;
  assign done    = (phase_q == PH_HOLD) && cnt_zero;

  // R9: done lasts a single clock
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: with waiting off, the last ACTIVE clock always moves to HOLD
  a_r6_no_wait_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACTIVE && cnt_zero && !ioen_q) |=> (phase_q == PH_HOLD));

  // R10: latched lengths never move while an access runs
  a_r10_lengths_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> ($stable(act_len_q) && $stable(hold_len_q) && $stable(ioen_q)));

  // R2: ACTIVE lasts at least two clocks
  a_r2_active_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q == PH_ACTIVE) |=> (phase_q == PH_ACTIVE));

  // R9: a request while busy never restarts the counter into SETUP
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && phase_q != PH_HOLD) |=> (phase_q != PH_SETUP || $past(phase_q) == PH_SETUP));

endmodule

// File: rtl/pio_bus_path.sv
module pio_bus_path
  import ide_pio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_write,
  input  logic              req_cmd,
  input  logic              narrow_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  pio_phase_e        phase,
  input  logic              capture,
  input  logic [DATA_W-1:0] rd_bus,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              cs_data,
  output logic              cs_cmd,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_oe,
  output logic [DATA_W-1:0] rd_data
);

  localparam int NARROW_W = DATA_W / 2;

  logic              wr_q, cmd_q;
  logic [DATA_W-1:0] wdata_q, rd_q;
  logic              wide_req;
  logic [DATA_W-1:0] wdata_fit, rd_fit;
  logic              busy, active, rd_en;

  // command class is always byte wide; data class unless narrowed
  assign wide_req = !req_cmd && !narrow_in;

  always_comb begin
    wdata_fit = wdata_in;
    if (!wide_req) wdata_fit = {{(DATA_W-NARROW_W){1'b0}}, wdata_in[NARROW_W-1:0]};
  end

  logic wide_q;

  always_comb begin
    rd_fit = rd_bus;
    if (!wide_q) rd_fit = {{(DATA_W-NARROW_W){1'b0}}, rd_bus[NARROW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      cmd_q   <= 1'b0;
      wide_q  <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      wr_q    <= req_write;
      cmd_q   <= req_cmd;
      wide_q  <= wide_req;
      wdata_q <= wdata_fit;
    end
  end

  assign rd_en = capture && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_fit;
  end

  assign busy      = (phase != PH_IDLE);
  assign active    = (phase == PH_ACTIVE);
  assign rd_strobe = active && !wr_q;
  assign wr_strobe = active && wr_q;
  assign cs_data   = busy && !cmd_q;
  assign cs_cmd    = busy && cmd_q;
  assign bus_oe    = busy && wr_q;
  assign bus_wdata = bus_oe ? wdata_q : '0;
  assign rd_data   = rd_q;

  // R5: strobes are exclusive
  a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));

  // R7: read data only moves on a read capture
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && !wr_q) |=> $stable(rd_q));

  // R10: direction and class cannot change inside an access
  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != PH_HOLD) |=> ($stable(wr_q) && $stable(cmd_q) && $stable(wdata_q)));

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_cmd,
  output logic              req_ready,
  input  logic [7:0]        data_timing,
  input  logic [7:0]        cmd_timing,
  input  logic              iordy_en,
  input  logic              narrow_en,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              cs_data,
  output logic              cs_cmd,
  output logic              rd_strobe,
  output logic              wr_strobe,
  input  logic              iordy,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] rd_bus,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);

  pio_tim_t   tim_sel;
  pio_phase_e phase;
  logic       start, capture;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  pio_timing_sel u_sel (
    .sel_cmd (req_cmd),
    .data_tb (data_timing),
    .cmd_tb  (cmd_timing),
    .tim     (tim_sel)
  );

  pio_phase_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tim_in  (tim_sel),
    .ioen_in (iordy_en),
    .iordy   (iordy),
    .phase   (phase),
    .capture (capture),
    .done    (done)
  );

  pio_bus_path #(.DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_write (req_write),
    .req_cmd   (req_cmd),
    .narrow_in (narrow_en),
    .wdata_in  (wdata_in),
    .phase     (phase),
    .capture   (capture),
    .rd_bus    (rd_bus),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .cs_data   (cs_data),
    .cs_cmd    (cs_cmd),
    .bus_wdata (bus_wdata),
    .bus_oe    (bus_oe),
    .rd_data   (rd_data)
  );

  // R1: a strobe is always preceded by a chip-select clock
  a_r1_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_strobe || wr_strobe) |-> $past(cs_data || cs_cmd));

  // R3: chip select remains after the strobe drops
  a_r3_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_strobe || wr_strobe) |-> (cs_data || cs_cmd));

  // R4: only one chip select at a time
  a_r4_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_data, cs_cmd}));

  // R9: done arrives with a chip select and no strobe
  a_r9_done_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((cs_data || cs_cmd) && !rd_strobe && !wr_strobe));

endmodule

// File: tb/test_ide_pio_timer.sv
module test_ide_pio_timer;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk, rst_n;
  logic          req_valid, req_write, req_cmd, req_ready;
  logic [7:0]    data_timing, cmd_timing;
  logic          iordy_en, narrow_en, iordy;
  logic [DW-1:0] wdata_in, bus_wdata, rd_bus, rd_data;
  logic          cs_data, cs_cmd, rd_strobe, wr_strobe, bus_oe, done;

  int checks = 0;
  int fails  = 0;
  int cyc_total = 0;

  ide_pio_timer #(.DATA_W(DW)) i_ide_pio_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cmd(req_cmd), .req_ready(req_ready), .data_timing(data_timing),
    .cmd_timing(cmd_timing), .iordy_en(iordy_en), .narrow_en(narrow_en),
    .wdata_in(wdata_in), .cs_data(cs_data), .cs_cmd(cs_cmd),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .iordy(iordy),
    .bus_wdata(bus_wdata), .bus_oe(bus_oe), .rd_bus(rd_bus),
    .rd_data(rd_data), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      fails++;
      $display("FAIL watchdog R9: actual %0d cycles expected < 150000", cyc_total);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_setup(input logic [7:0] tb);
    return int'(tb[7:6]) + 1;
  endfunction

  function automatic int exp_hold(input logic [7:0] tb);
    case (tb[5:3])
      3'd0: return 1;  3'd1: return 2;  3'd2: return 3;  3'd3: return 4;
      3'd4: return 5;  3'd5: return 6;  3'd6: return 8;  default: return 12;
    endcase
  endfunction

  function automatic int exp_active(input logic [7:0] tb);
    case (tb[2:0])
      3'd0: return 2;  3'd1: return 3;  3'd2: return 4;  3'd3: return 5;
      3'd4: return 6;  3'd5: return 8;  3'd6: return 12; default: return 16;
    endcase
  endfunction

  task automatic run_access(input bit w, input bit c, input bit ioen, input bit nar,
                            input logic [7:0] dtb, input logic [7:0] ctb,
                            input logic [DW-1:0] wd, input int stall, input bit poke);
    logic [7:0]    tb;
    int            es, ea, eh;
    int            s_cnt, a_cnt, h_cnt, d_cnt;
    bit            seen_strobe, cs_bad, dir_bad, wr_bad, ready_bad, done_bad, finished;
    bit            wide;
    logic [DW-1:0] last_rd, rd_before, exp_w;
    tb    = c ? ctb : dtb;
    es    = exp_setup(tb);
    eh    = exp_hold(tb);
    ea    = exp_active(tb);
    if (ioen && (stall + 1 > ea)) ea = stall + 1;
    wide  = !c && !nar;
    exp_w = wide ? wd : {8'h00, wd[7:0]};
    s_cnt = 0; a_cnt = 0; h_cnt = 0; d_cnt = 0;
    seen_strobe = 0; cs_bad = 0; dir_bad = 0; wr_bad = 0; ready_bad = 0; done_bad = 0;
    finished = 0; last_rd = '0;

    @(negedge clk);
    rd_before   = rd_data;
    req_valid   = 1'b1; req_write = w; req_cmd = c;
    data_timing = dtb;  cmd_timing = ctb;
    iordy_en    = ioen; narrow_en = nar; wdata_in = wd; iordy = 1'b1;

    for (int cyc = 0; cyc < 200 && !finished; cyc++) begin
      @(negedge clk);
      // sample
      if (req_ready) ready_bad = 1;
      if (!(cs_data || cs_cmd) || cs_cmd != c || cs_data == c) cs_bad = 1;
      if (rd_strobe || wr_strobe) begin
        a_cnt++;
        seen_strobe = 1;
        if (wr_strobe != w || rd_strobe == w) dir_bad = 1;
      end else if (!seen_strobe) s_cnt++;
      else h_cnt++;
      if (w) begin
        if (!bus_oe || bus_wdata !== exp_w) wr_bad = 1;
      end else if (bus_oe) wr_bad = 1;
      if (done) begin
        d_cnt++;
        if (rd_strobe || wr_strobe || !seen_strobe) done_bad = 1;
        finished = 1;
      end
      // drive for the next edge; scrambled configuration must be ignored (R10)
      req_valid   = poke && (rd_strobe || wr_strobe) && a_cnt == 1;
      req_write   = ~w;
      req_cmd     = ~c;
      data_timing = 8'($urandom);
      cmd_timing  = 8'($urandom);
      iordy_en    = ~ioen;
      narrow_en   = ~nar;
      wdata_in    = 16'($urandom);
      rd_bus      = 16'($urandom);
      if (rd_strobe || wr_strobe) begin
        last_rd = rd_bus;
        iordy   = (a_cnt > stall);
      end else begin
        iordy = 1'b1;
      end
    end
    req_valid = 1'b0;
    iordy     = 1'b1;

    chk(s_cnt == es, "R1 setup clocks", s_cnt, es);
    chk(a_cnt == ea, "R2/R6 strobe clocks", a_cnt, ea);
    chk(h_cnt == eh, "R3 hold clocks", h_cnt, eh);
    chk(!cs_bad, "R4 chip select class/continuity", cs_bad, 0);
    chk(!dir_bad, "R5 strobe direction", dir_bad, 0);
    chk(!wr_bad, "R8 write data / output enable", wr_bad, 0);
    chk(d_cnt == 1 && !done_bad, "R9 done pulse", d_cnt, 1);
    chk(!ready_bad, "R9 ready low while busy", ready_bad, 0);
    if (w) chk(rd_data === rd_before, "R7 write leaves rd_data", rd_data, rd_before);
    else   chk(rd_data === (wide ? last_rd : {8'h00, last_rd[7:0]}), "R7 read capture",
               rd_data, wide ? last_rd : {8'h00, last_rd[7:0]});

    // one clock after done: idle, and a request raised while busy left no trace
    @(negedge clk);
    chk(req_ready && !cs_data && !cs_cmd && !rd_strobe && !wr_strobe && !done,
        "R9 idle after done", {req_ready, cs_data, cs_cmd, rd_strobe, wr_strobe, done}, 6'b100000);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_cmd = 1'b0;
    data_timing = 8'h00; cmd_timing = 8'h00; iordy_en = 1'b0; narrow_en = 1'b0;
    iordy = 1'b1; wdata_in = '0; rd_bus = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready && !cs_data && !cs_cmd && !rd_strobe && !wr_strobe && !bus_oe && !done,
        "R11 reset controls", {req_ready, cs_data, cs_cmd, rd_strobe, wr_strobe, bus_oe, done},
        7'b1000000);
    chk(rd_data == '0, "R11 reset rd_data", rd_data, 0);

    // fastest and slowest bytes
    run_access(0, 0, 0, 0, 8'h00, 8'hFF, 16'h1234, 0, 0);
    run_access(1, 1, 0, 0, 8'h00, 8'hFF, 16'hBEEF, 0, 0);
    // sweep every code of each field (R1 R2 R3)
    for (int k = 0; k < 8; k++) begin
      logic [7:0] b;
      b = {2'(k), 3'(k), 3'(k)};
      run_access(0, 0, 0, 0, b, 8'h00, 16'h0, 0, 0);
      run_access(1, 1, 0, 0, 8'h00, {2'(7-k), 3'(7-k), 3'(k)}, 16'hA5C3, 0, 0);
    end
    // R6 IORDY: stretch, exact boundary, and disabled
    run_access(0, 0, 1, 0, 8'h00, 8'h00, 16'h0, 9, 0);   // 2 -> 10
    run_access(0, 0, 1, 0, 8'h02, 8'h00, 16'h0, 3, 0);   // 4 stays 4
    run_access(0, 0, 1, 0, 8'h02, 8'h00, 16'h0, 4, 0);   // 4 -> 5
    run_access(1, 0, 0, 0, 8'h00, 8'h00, 16'h7777, 12, 0); // ignored
    // R7 R8 narrow handling
    run_access(0, 0, 0, 1, 8'h49, 8'h00, 16'h0, 0, 0);
    run_access(1, 0, 0, 1, 8'h49, 8'h00, 16'hFACE, 0, 0);
    run_access(0, 1, 0, 0, 8'h00, 8'h49, 16'h0, 0, 0);
    // R9 request while busy is dropped
    run_access(0, 0, 0, 0, 8'h0D, 8'h00, 16'h0, 0, 1);
    run_access(1, 1, 1, 0, 8'h00, 8'h8B, 16'h55AA, 6, 1);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      run_access(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 8'($urandom), 8'($urandom), 16'($urandom),
                 int'($urandom_range(0, 20)), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule